// File: doc/BRIEF.md
# Sign-Bit Averaging DC Offset Canceller

This block sits in front of a companding encoder and takes DC offset out of the stream of signed samples fed to it. It does not look at the sample magnitudes. Instead it watches the sign bit of each encoded word that comes back from the encoder. A bit that says positive moves a saturating accumulator up by one step, and a bit that says negative moves it down by one step. The upper bits of the accumulator form a signed correction, and that correction is subtracted from the next input sample. Once the loop settles, positive and negative codes occur equally often, so the encoder input carries no DC offset.

Samples arrive with a valid strobe once per 8 kHz frame. The corrected sample leaves through a register one cycle later. A settled flag goes high after a programmable number of frames following reset or a synchronous clear. The default of 480 frames matches a 60 ms settling time. The ratio of accumulator width to correction width sets the time constant: each correction LSB needs 2^(ACC_W-CORR_W) net sign steps.

Top module: `dc_offset_canceller`

## Requirements
- R1: While rst_ni is low and after it is released, smp_o is 0, smp_valid_o is 0, settled_o is 0, and the accumulator is 0.
- R2: On a cycle with code_valid_i high, code_sign_i = 1 (positive code) adds one to the accumulator and code_sign_i = 0 (negative code) subtracts one. When code_valid_i is low, code_sign_i has no effect.
- R3: The correction is the top CORR_W bits of the accumulator taken as a signed value. This equals floor(acc / 2^(ACC_W-CORR_W)).
- R4: The output sample is smp_i minus the sign-extended correction, saturated to the signed SAMPLE_W range.
- R5: smp_valid_o is high in the cycle after each accepted smp_valid_i and carries that sample's result. A sign step in the same cycle as the sample does not affect that sample; it affects the next one.
- R6: The accumulator saturates at its signed limits (2^(ACC_W-1)-1 and -2^(ACC_W-1)) instead of wrapping.
- R7: settled_o goes high once SETTLE_FRAMES valid samples have been counted since the last reset or clear, and it stays high until the next clear or reset.
- R8: clr_i is synchronous. It zeroes the accumulator, the frame count and smp_valid_o, and it takes priority over a sample or a sign step in the same cycle.
- R9: In a cycle after smp_valid_i was low, smp_valid_o is low and smp_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of estimate, count and output valid |
| smp_i | input | SAMPLE_W | Signed input sample |
| smp_valid_i | input | 1 | Input sample strobe, once per frame |
| code_sign_i | input | 1 | Sign bit of the encoded word, 1 = positive |
| code_valid_i | input | 1 | Qualifies code_sign_i |
| smp_o | output | SAMPLE_W | Corrected, saturated output sample |
| smp_valid_o | output | 1 | Output sample strobe |
| settled_o | output | 1 | Settling period has elapsed |

## Verification
A corrected sample is due exactly one clock after its input strobe. The correction it uses is the accumulator value from before any sign step taken in that same cycle. Every sign step or sample is driven on a falling edge, and every output is read on the next falling edge, which is half a cycle after the register that produces it. A sign step therefore shows up in the result of the first sample driven after it. settled_o is a decode of a counter that updates at the edge capturing the SETTLE_FRAMES-th strobe, so the bench reads it on the falling edge after the 19th and the 20th samples with the bench's own setting of 20 frames.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  // Direction of one accumulator step decoded from the encoder sign feedback
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } step_dir_e;

  localparam logic SIGN_POSITIVE = 1'b1;
endpackage

// File: rtl/dcc_sign_accum.sv
`timescale 1ns/1ps
module dcc_sign_accum
  import dcc_pkg::*;
#(
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned CORR_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  step_dir_e                dir_i,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ACC_ONE = ACC_W'(1);

  logic signed [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    unique case (dir_i)
      DIR_UP:  if (acc_q != ACC_MAX) acc_d = acc_q + ACC_ONE;
      DIR_DN:  if (acc_q != ACC_MIN) acc_d = acc_q - ACC_ONE;
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else             acc_q <= acc_d;
  end

  // correction = upper bits, i.e. floor(acc / 2^(ACC_W-CORR_W))
  assign corr_o = acc_q[ACC_W-1 -: CORR_W];

  AST_ACC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0); // R8
  AST_ACC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == DIR_HOLD && !clr_i) |=> $stable(acc_q)); // R2
  AST_ACC_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == ACC_MAX && dir_i == DIR_UP && !clr_i) |=> acc_q == ACC_MAX); // R6
  AST_ACC_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == ACC_MIN && dir_i == DIR_DN && !clr_i) |=> acc_q == ACC_MIN); // R6
  AST_ACC_UP_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == DIR_UP && !clr_i && !acc_q[ACC_W-1]) |=> !acc_q[ACC_W-1]); // R6
endmodule

// File: rtl/dcc_settle_timer.sv
`timescale 1ns/1ps
module dcc_settle_timer #(
  parameter int unsigned SETTLE_FRAMES = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic settled_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_FRAMES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_END) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign settled_o = (cnt_q == CNT_END);

  AST_SETTLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_o && !clr_i) |=> settled_o); // R7
  AST_SETTLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !settled_o); // R8
  AST_SETTLE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!settled_o && !tick_i) |=> !settled_o); // R7
endmodule

// File: rtl/dcc_out_stage.sv
`timescale 1ns/1ps
module dcc_out_stage #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned CORR_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       smp_valid_i,
  input  logic signed [CORR_W-1:0]   corr_i,
  output logic signed [SAMPLE_W-1:0] smp_o,
  output logic                       smp_valid_o
);
  localparam int unsigned DIFF_W = SAMPLE_W + 1;
  localparam logic signed [SAMPLE_W-1:0] SMP_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] SMP_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] corr_ext;
  logic signed [DIFF_W-1:0]   diff;
  logic signed [SAMPLE_W-1:0] sat;

  generate
    if (CORR_W == SAMPLE_W) begin : g_corr_full
      assign corr_ext = corr_i;
    end else begin : g_corr_sext
      assign corr_ext = {{(SAMPLE_W-CORR_W){corr_i[CORR_W-1]}}, corr_i};
    end
  endgenerate

  always_comb begin
    diff = {smp_i[SAMPLE_W-1], smp_i} - {corr_ext[SAMPLE_W-1], corr_ext};
    if (diff[DIFF_W-1] != diff[DIFF_W-2]) sat = diff[DIFF_W-1] ? SMP_MIN : SMP_MAX;
    else                                  sat = diff[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o       <= '0;
      smp_valid_o <= 1'b0;
    end else if (clr_i) begin
      smp_o       <= '0;
      smp_valid_o <= 1'b0;
    end else begin
      smp_valid_o <= smp_valid_i;
      if (smp_valid_i) smp_o <= sat;
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !clr_i) |=> smp_valid_o); // R5
  AST_OUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !smp_valid_o); // R9
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !clr_i) |=> $stable(smp_o)); // R9
  AST_OUT_NO_NEG_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !clr_i && !smp_i[SAMPLE_W-1] && corr_ext[SAMPLE_W-1])
      |=> !smp_o[SAMPLE_W-1]); // R4
  AST_OUT_NO_POS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !clr_i && smp_i[SAMPLE_W-1] && !corr_ext[SAMPLE_W-1])
      |=> smp_o[SAMPLE_W-1]); // R4
endmodule

// File: rtl/dc_offset_canceller.sv
`timescale 1ns/1ps
module dc_offset_canceller
  import dcc_pkg::*;
#(
  parameter int unsigned SAMPLE_W      = 14,
  parameter int unsigned ACC_W         = 16,
  parameter int unsigned CORR_W        = 8,
  parameter int unsigned SETTLE_FRAMES = 480
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       smp_valid_i,
  input  logic                       code_sign_i,
  input  logic                       code_valid_i,
  output logic signed [SAMPLE_W-1:0] smp_o,
  output logic                       smp_valid_o,
  output logic                       settled_o
);
  step_dir_e                 dir;
  logic signed [CORR_W-1:0]  corr;

  always_comb begin
    if (!code_valid_i)                    dir = DIR_HOLD;
    else if (code_sign_i == SIGN_POSITIVE) dir = DIR_UP;
    else                                  dir = DIR_DN;
  end

  dcc_sign_accum #(.ACC_W(ACC_W), .CORR_W(CORR_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .dir_i  (dir),
    .corr_o (corr)
  );

  dcc_out_stage #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .smp_i       (smp_i),
    .smp_valid_i (smp_valid_i),
    .corr_i      (corr),
    .smp_o       (smp_o),
    .smp_valid_o (smp_valid_o)
  );

  dcc_settle_timer #(.SETTLE_FRAMES(SETTLE_FRAMES)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .tick_i    (smp_valid_i),
    .settled_o (settled_o)
  );

  AST_TOP_RESET_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!smp_valid_o && !settled_o)); // R1
endmodule

// File: tb/dc_offset_canceller_tb.sv
`timescale 1ns/1ps
module dc_offset_canceller_tb;
  localparam int SW = 14;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0;
  logic signed [SW-1:0] smp_i = '0;
  logic smp_valid_i = 1'b0;
  logic code_sign_i = 1'b0;
  logic code_valid_i = 1'b0;
  logic signed [SW-1:0] smp_o;
  logic smp_valid_o;
  logic settled_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  // ACC_W-CORR_W = 4: one correction LSB per 16 net steps, acc range -512..511
  dc_offset_canceller #(.SAMPLE_W(SW), .ACC_W(10), .CORR_W(6), .SETTLE_FRAMES(20)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .smp_i(smp_i),
    .smp_valid_i(smp_valid_i), .code_sign_i(code_sign_i), .code_valid_i(code_valid_i),
    .smp_o(smp_o), .smp_valid_o(smp_valid_o), .settled_o(settled_o)
  );

  // {net steps after clear, input sample, expected output}
  localparam int VEC [10][3] = '{
    '{   0,   100,   100},
    '{  16,   100,    99},
    '{  15,   100,   100},
    '{  -1,   100,   101},
    '{ -16,   -50,   -49},
    '{ -17,     0,     2},
    '{  33,     0,    -2},
    '{  40, -8192, -8192},
    '{ -40,  8191,  8191},
    '{  48, -8190, -8192}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < (n < 0 ? -n : n); i++) begin
      code_valid_i = 1'b1;
      code_sign_i  = (n > 0);
      @(negedge clk_i);
    end
    code_valid_i = 1'b0;
  endtask

  task automatic sample(input int v);
    smp_i = SW'(v);
    smp_valid_i = 1'b1;
    @(negedge clk_i);
    smp_valid_i = 1'b0;
  endtask

  task automatic clear();
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 smp_valid_o in reset", int'(smp_valid_o), 0);
    chk("R1 settled_o in reset", int'(settled_o), 0);
    chk("R1 smp_o in reset", int'(smp_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    sample(37);
    chk("R1 zero correction after reset", int'(smp_o), 37);

    // R3 R4 table walk
    foreach (VEC[k]) begin
      clear();
      steps(VEC[k][0]);
      sample(VEC[k][1]);
      chk($sformatf("R3/R4 vec%0d valid", k), int'(smp_valid_o), 1);
      chk($sformatf("R3/R4 vec%0d out", k), int'(smp_o), VEC[k][2]);
    end

    // R5 latency and same-cycle step
    clear();
    steps(15);
    smp_i = '0; smp_valid_i = 1'b1; code_valid_i = 1'b1; code_sign_i = 1'b1;
    @(negedge clk_i);
    smp_valid_i = 1'b0; code_valid_i = 1'b0;
    chk("R5 valid one cycle later", int'(smp_valid_o), 1);
    chk("R5 same-cycle step not used", int'(smp_o), 0);
    sample(0);
    chk("R5 step used by next sample", int'(smp_o), -1);

    // R9 hold when idle
    clear();
    sample(77);
    repeat (3) @(negedge clk_i);
    chk("R9 valid low when idle", int'(smp_valid_o), 0);
    chk("R9 smp_o holds", int'(smp_o), 77);

    // R2 sign ignored without code_valid_i
    clear();
    code_valid_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      code_sign_i = i[0];
      @(negedge clk_i);
    end
    sample(0);
    chk("R2 unqualified sign ignored", int'(smp_o), 0);
    steps(-16);
    sample(0);
    chk("R2 negative codes step down", int'(smp_o), 1);

    // R6 saturation at both ends
    clear();
    steps(600);
    sample(0);
    chk("R6 top saturation", int'(smp_o), -31);
    steps(-16);
    sample(0);
    chk("R6 leave top limit", int'(smp_o), -30);
    steps(-1200);
    sample(0);
    chk("R6 bottom saturation", int'(smp_o), 32);
    steps(16);
    sample(0);
    chk("R6 leave bottom limit", int'(smp_o), 31);

    // R8 clear priority over sample and step
    clr_i = 1'b1; smp_i = SW'(5); smp_valid_i = 1'b1;
    code_valid_i = 1'b1; code_sign_i = 1'b0;
    @(negedge clk_i);
    clr_i = 1'b0; smp_valid_i = 1'b0; code_valid_i = 1'b0;
    chk("R8 clear drops sample", int'(smp_valid_o), 0);
    sample(0);
    chk("R8 clear zeroes estimate and drops step", int'(smp_o), 0);

    // R7 settle count
    clear();
    for (int i = 0; i < 19; i++) sample(0);
    chk("R7 not settled after 19 frames", int'(settled_o), 0);
    sample(0);
    chk("R7 settled after 20 frames", int'(settled_o), 1);
    repeat (5) @(negedge clk_i);
    sample(0);
    chk("R7 settled stays high", int'(settled_o), 1);
    clear();
    chk("R8 clear drops settled", int'(settled_o), 0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule